// File: doc/BRIEF.md
# Daisy-Chain Serial Control-Word Router

This block is the serial front end of one node in a chain of codec nodes that share a single serial path to a host. Every word enters on a serial data input, most significant bit first, with a one-cycle input frame pulse on its first bit. The block collects the sixteen bits and then does one of four things with the word. It stores the word as a register write and sends nothing on. It returns a register value as a reply word. It passes the word on with its hop field lowered by one. Or it passes the word on unchanged. Each output word leaves on the serial data output with a one-cycle output frame pulse on its first bit. That pulse feeds the input frame of the next node.

Nodes are addressed by position. A control word carries a three-bit hop field. A node acts on a control word only when that field arrives as zero. Otherwise it lowers the field by one and passes the word on. A local sample strobe queues the node's own sample word for output. Eight 8-bit configuration registers set the node's mode and clock setting. Register 0 holds the chain length, a mixed-mode bit and a data-mode bit. Register 1 holds the clock setting.

Top module: `chain_word_router`

## Requirements
- R1: A pulse on `sdifs` marks the first bit of a word. That bit and the next fifteen bits on `sdi` form a 16-bit word, most significant bit first, one bit per clock.
- R2: Each output word is sent on `sdo` most significant bit first, with `sdofs` high for exactly the cycle of that first bit. When the transmitter is free, this first bit appears in the cycle right after the clock edge that captures the sixteenth input bit.
- R3: A word is decoded as control when bit 15 is 1 and control decoding is enabled. Decoding is enabled in program mode (register 0 bit 4 = 0) or in mixed mode (register 0 bit 3 = 1). Control word fields: bit 14 is the read flag (1 = read), bits 13:11 are the hop field, bits 10:8 select the register, and bits 7:0 are the data.
- R4: A control write whose hop field is zero stores bits 7:0 into the selected register and produces no output frame.
- R5: A control word whose hop field is nonzero is sent on with the hop field lowered by one. All other bits are unchanged.
- R6: A word that is not decoded as control is sent on unchanged.
- R7: A control read whose hop field is zero produces the reply word {1, 1, 3'b111, register index, register value}.
- R8: A pulse on `smp_evt` captures `smp_word` and sends it when the transmitter is next free. A routed word completing in the same cycle goes out first, and the sample word follows with no gap.
- R9: In data mode without mixed mode, no word is decoded as control. A word with bit 15 set is sent on unchanged and no register changes.
- R10: All registers reset to zero. `dev_count` shows register 0 bits 2:0, `mixed_mode` shows bit 3, `data_mode` shows bit 4, and `clk_cfg` shows register 1.
- R11: Words that arrive back to back leave back to back, sixteen cycles apart, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial data from the upstream node or the host |
| sdifs | input | 1 | Input frame pulse on the first bit of a word |
| smp_evt | input | 1 | Local sample strobe |
| smp_word | input | 16 | Local sample word |
| sdo | output | 1 | Serial data toward the next node |
| sdofs | output | 1 | Output frame pulse on the first bit of a word |
| dev_count | output | 3 | Chain length field of register 0 |
| mixed_mode | output | 1 | Mixed-mode bit of register 0 |
| data_mode | output | 1 | Data-mode bit of register 0 |
| clk_cfg | output | 8 | Contents of register 1 |

## Verification
The bench checks the exact output cycle of a routed word. A design that added a staging register would start its frame one cycle late. A hop field of zero on a read must return as all ones. A design that skipped the wrap, or handled a read as a write, would return the wrong field or send nothing. Two collisions are driven. In one, a sample strobe lands on the last input bit. In the other, two words arrive back to back. A design with no holding slot would drop a word or place a gap between frames. The mode tests switch between mixed mode and data-only mode. A design that still decodes control words in data-only mode would consume a forwarded write and change the clock setting.

// File: rtl/chain_word_router.sv
module chain_word_router #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         sdifs,
  input  logic         smp_evt,
  input  logic [W-1:0] smp_word,
  output logic         sdo,
  output logic         sdofs,
  output logic [2:0]   dev_count,
  output logic         mixed_mode,
  output logic         data_mode,
  output logic [7:0]   clk_cfg
);
  localparam int CW = $clog2(W);
  localparam int TW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [TW-1:0] FULL = TW'(W);

  logic [NREG-1:0][7:0] cfg;
  logic [W-1:0]  rx_sh, tx_sh, hold_w, samp_w, rx_word, out_w;
  logic [CW-1:0] rx_cnt;
  logic [TW-1:0] tx_cnt;
  logic          rx_busy, hold_v, samp_v;
  logic          rx_done, is_ctl, hit, wr_hit, want, tx_free;
  logic [2:0]    hop;
  logic [2:0]    sel;

  assign rx_done = rx_busy && rx_cnt == LAST;
  assign rx_word = {rx_sh[W-2:0], sdi};
  assign hop     = rx_word[13:11];
  assign sel     = rx_word[10:8];
  assign is_ctl  = rx_word[15] && (!cfg[0][4] || cfg[0][3]);
  assign hit     = is_ctl && hop == 3'd0;
  assign wr_hit  = hit && !rx_word[14];
  assign want    = rx_done && !wr_hit;
  assign tx_free = tx_cnt <= TW'(1);
  assign out_w   = is_ctl ? {rx_word[15:14], hop - 3'd1, sel, hit ? cfg[sel] : rx_word[7:0]}
                          : rx_word;

  assign sdo        = tx_cnt != '0 && tx_sh[W-1];
  assign dev_count  = cfg[0][2:0];
  assign mixed_mode = cfg[0][3];
  assign data_mode  = cfg[0][4];
  assign clk_cfg    = cfg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      rx_cnt  <= '0;
      rx_busy <= 1'b0;
    end else begin
      rx_sh <= rx_word;
      if (rx_busy) begin
        rx_busy <= !rx_done;
        rx_cnt  <= rx_done ? '0 : rx_cnt + 1'b1;
      end else if (sdifs) begin
        rx_busy <= 1'b1;
        rx_cnt  <= CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (rx_done && wr_hit) cfg[sel] <= rx_word[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_cnt <= '0;
      sdofs  <= 1'b0;
      hold_v <= 1'b0;
      hold_w <= '0;
      samp_v <= 1'b0;
      samp_w <= '0;
    end else begin
      sdofs <= 1'b0;
      if (tx_cnt != '0) begin
        tx_sh  <= tx_sh << 1;
        tx_cnt <= tx_cnt - 1'b1;
      end
      if (tx_free && (hold_v || want || samp_v)) begin
        sdofs  <= 1'b1;
        tx_cnt <= FULL;
        if (hold_v) begin
          tx_sh  <= hold_w;
          hold_v <= want;
          hold_w <= out_w;
        end else if (want) begin
          tx_sh <= out_w;
        end else begin
          tx_sh  <= samp_w;
          samp_v <= 1'b0;
        end
      end else if (want) begin
        hold_v <= 1'b1;
        hold_w <= out_w;
      end
      if (smp_evt) begin
        samp_v <= 1'b1;
        samp_w <= smp_word;
      end
    end
  end

  p_frame_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sdofs |=> !sdofs);
  p_frame_pulse_on_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sdofs |-> tx_cnt == FULL);
  p_hold_no_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (want && !tx_free) |-> !hold_v);
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode && !mixed_mode) |=> $stable(cfg));
  p_write_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && wr_hit && !hold_v && !samp_v && tx_free) |=> !sdofs);
endmodule

// File: tb/sim_chain_word_router.sv
module sim_chain_word_router;
  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0, sdifs = 1'b0, smp_evt = 1'b0;
  logic [15:0] smp_word = '0;
  logic sdo, sdofs, mixed_mode, data_mode;
  logic [2:0] dev_count;
  logic [7:0] clk_cfg;

  int checks = 0, errors = 0, cyc = 0, nfrm = 0, mcnt = 0, mstart = 0, tend = 0;
  logic [15:0] msh;
  logic [15:0] frm [0:63];
  int fcyc [0:63];
  bit done = 0;

  chain_word_router u0 (.clk(clk), .rst_n(rst_n), .sdi(sdi), .sdifs(sdifs),
    .smp_evt(smp_evt), .smp_word(smp_word), .sdo(sdo), .sdofs(sdofs),
    .dev_count(dev_count), .mixed_mode(mixed_mode), .data_mode(data_mode),
    .clk_cfg(clk_cfg));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (mcnt == 0) begin
      if (sdofs) begin msh = {15'b0, sdo}; mcnt = 1; mstart = cyc; end
    end else begin
      if (sdofs) begin
        errors++; $display("FAIL R2 frame pulse mid-word: actual 1 expected 0");
      end
      msh = {msh[14:0], sdo};
      mcnt++;
      if (mcnt == 16) begin
        if (nfrm < 64) begin frm[nfrm] = msh; fcyc[nfrm] = mstart; end
        nfrm++; mcnt = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input bit evt_last);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      sdi = w[i]; sdifs = (i == 15); smp_evt = evt_last && i == 0;
      if (i == 0) tend = cyc + 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdi = 0; sdifs = 0; smp_evt = 0;
    end
  endtask

  task automatic t_reset;
    chk("R10 sdofs", sdofs, 0);
    chk("R10 dev_count", dev_count, 0);
    chk("R10 modes", {mixed_mode, data_mode}, 0);
    chk("R10 clk_cfg", clk_cfg, 0);
  endtask

  task automatic t_write;
    int b = nfrm;
    send(16'h815A, 0); idle(40);
    chk("R4 write emits nothing", nfrm - b, 0);
    chk("R4 stored", clk_cfg, 8'h5A);
  endtask

  task automatic t_forward;
    int b = nfrm, e;
    send(16'h9AC3, 0); e = tend; idle(40);
    chk("R5 one frame", nfrm - b, 1);
    chk("R5 hop lowered", frm[b], 16'h92C3);
    chk("R2 first bit cycle", fcyc[b], e);
  endtask

  task automatic t_read;
    int b = nfrm;
    send(16'hC100, 0); idle(40);
    chk("R7 reply count", nfrm - b, 1);
    chk("R7 reply word", frm[b], 16'hF95A);
  endtask

  task automatic t_plain;
    int b = nfrm;
    send(16'h1234, 0); idle(40);
    chk("R6 data word unchanged", frm[b], 16'h1234);
    chk("R1 capture count", nfrm - b, 1);
  endtask

  task automatic t_sample;
    int b = nfrm;
    @(negedge clk); smp_word = 16'hABCD; smp_evt = 1;
    idle(40);
    chk("R8 sample frame", frm[b], 16'hABCD);
  endtask

  task automatic t_collide;
    int b = nfrm;
    smp_word = 16'h5555;
    send(16'h2222, 1); idle(60);
    chk("R8 routed first", frm[b], 16'h2222);
    chk("R8 sample second", frm[b+1], 16'h5555);
    chk("R8 no gap", fcyc[b+1] - fcyc[b], 16);
  endtask

  task automatic t_b2b;
    int b = nfrm;
    send(16'h0F0F, 0); send(16'h9AC3, 0); idle(60);
    chk("R11 first", frm[b], 16'h0F0F);
    chk("R11 second", frm[b+1], 16'h92C3);
    chk("R11 spacing", fcyc[b+1] - fcyc[b], 16);
  endtask

  task automatic t_modes;
    int b;
    send(16'h801A, 0); idle(20);
    chk("R10 dev_count", dev_count, 2);
    chk("R10 mixed and data", {mixed_mode, data_mode}, 2'b11);
    b = nfrm;
    send(16'h8177, 0); idle(40);
    chk("R3 mixed control write", clk_cfg, 8'h77);
    chk("R3 mixed write silent", nfrm - b, 0);
    send(16'h8012, 0); idle(20);
    chk("R10 data only", {mixed_mode, data_mode}, 2'b01);
    b = nfrm;
    send(16'h8133, 0); idle(40);
    chk("R9 forwarded unchanged", frm[b], 16'h8133);
    chk("R9 register kept", clk_cfg, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    idle(3);
    t_write; t_forward; t_read; t_plain; t_sample; t_collide; t_b2b; t_modes;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule